// File: doc/BRIEF.md
# Periodic Rate and Interrupt Flag Unit

This block turns a 65.536 kHz tick enable into one of fifteen periodic rates, each a power-of-two division of that tick. Rate code 0 turns the periodic source off. Code 1 gives an event every second tick, which is about 32.8 kHz. Each higher code doubles the period, so code 15 gives 2 Hz. The periodic events drive a square-wave output that can be enabled. They also set a periodic flag.

The periodic flag sits in an 8-bit flag register next to an alarm flag and an update-ended flag. The alarm and update-ended events come from the calendar logic outside this block. A read strobe returns the register and clears it in the same access. The top bit of the register is a summary: it is set when any flag is set together with its enable. The interrupt request follows that summary bit. A 3-bit divider control field holds the rate counter in reset when it carries one of two reserved codes.

Top module: `prd_rate_irq_unit`

## Requirements
- R1: After reset, `flags` is 0x00, `irq` is 0 and `sqw` is 0.
- R2: With `rate_code` = n (1..15), a periodic event occurs on the tick_en cycle that completes each block of 2^n ticks, counted from reset or from release of the divider hold. Cycles without `tick_en` do not advance the count.
- R3: With `rate_code` = 0, no periodic event occurs and the periodic flag is never set by the divider.
- R4: While `div_ctl` is 6 or 7, the rate counter is held at zero and no periodic event occurs. After release, counting restarts from zero.
- R5: The periodic flag (`flags` bit 6) is set in the cycle after a periodic event, whatever the value of `per_ie`.
- R6: The alarm flag (`flags` bit 5) and the update flag (`flags` bit 4) are set in the cycle after a pulse on `alarm_evt` or `update_evt`. Bits 3:0 always read 0.
- R7: In the cycle of a `flag_rd` pulse, `flags` shows the current value. From the next cycle all flags are clear, except that an event arriving in the same cycle as the read sets its flag.
- R8: `flags` bit 7 is set exactly when a flag is set with its enable set (bit 6 with `per_ie`, bit 5 with `alm_ie`, bit 4 with `upd_ie`). It follows the enables in the same cycle.
- R9: `irq` always equals `flags` bit 7.
- R10: When `sqw_en` is 1 and `rate_code` is nonzero, `sqw` toggles in the cycle after each periodic event. Otherwise `sqw` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Single-cycle 65.536 kHz tick |
| div_ctl | input | 3 | Divider control; 6 or 7 holds the counter in reset |
| rate_code | input | 4 | Periodic rate select; 0 = off |
| per_ie | input | 1 | Periodic interrupt enable |
| alm_ie | input | 1 | Alarm interrupt enable |
| upd_ie | input | 1 | Update-ended interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| alarm_evt | input | 1 | Alarm event pulse |
| update_evt | input | 1 | Update-ended event pulse |
| flag_rd | input | 1 | Read strobe; clears the flag register |
| flags | output | 8 | {summary, periodic, alarm, update, 4'b0} |
| irq | output | 1 | Interrupt request |
| sqw | output | 1 | Square-wave output |

## Verification
The bench builds the block with its default parameters: a 15-bit rate counter and a 4-bit rate code. With those values every rate code, up to the 32768-tick period of code 15, can be reached in the run. A long phase ticks on every cycle, so the slowest rate completes a full period and wraps the counter. Other phases gap the ticks to show that idle cycles do not advance the count. Further phases hold and then release the divider, and land reads on the same cycle as events.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int FLAG_W   = 8;
  localparam int BIT_SUM  = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_ALM  = 5;
  localparam int BIT_UPD  = 4;
  localparam int DIVCTL_W = 3;
  localparam int NSRC     = 3;
  // source vector order: {periodic, alarm, update}
  localparam int SRC_PER  = 2;
  localparam int SRC_ALM  = 1;
  localparam int SRC_UPD  = 0;

  // divider reset codes hold the rate counter
  function automatic logic divider_held(input logic [DIVCTL_W-1:0] ctl);
    return (ctl == 3'd6) || (ctl == 3'd7);
  endfunction

  function automatic logic summary_of(input logic [NSRC-1:0] f, input logic [NSRC-1:0] en);
    return |(f & en);
  endfunction

  function automatic logic [FLAG_W-1:0] pack_flags(input logic sum, input logic [NSRC-1:0] f);
    return {sum, f, {(FLAG_W-1-NSRC){1'b0}}};
  endfunction
endpackage

// File: rtl/prd_divider.sv
module prd_divider #(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick_en,
  input  logic [prd_pkg::DIVCTL_W-1:0]  div_ctl,
  input  logic [CODE_W-1:0]             rate_code,
  output logic                          rate_evt,
  output logic                          held
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // event when the low `code` bits of the counter are all ones
  function automatic logic rate_match(input logic [CNT_W-1:0] c, input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] m;
    m = ~(ONES << code);
    return (code != '0) && ((c & m) == m);
  endfunction

  assign held     = prd_pkg::divider_held(div_ctl);
  assign rate_evt = tick_en && !held && rate_match(cnt_q, rate_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (held)    cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + ONE;
  end

  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (cnt_q == '0));
  assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !rate_evt);
  assert_code_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == '0) |-> !rate_evt);
  assert_need_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |-> !rate_evt);
endmodule

// File: rtl/prd_sqwave.sv
module prd_sqwave (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_evt,
  input  logic sqw_en,
  input  logic rate_on,
  output logic sqw
);
  logic sq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sq_q <= 1'b0;
    else if (!sqw_en || !rate_on) sq_q <= 1'b0;
    else if (rate_evt)           sq_q <= ~sq_q;
  end

  assign sqw = sq_q;

  assert_sqw_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |=> !sqw);
  assert_sqw_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sqw_en && rate_on && rate_evt) |=> (sqw != $past(sqw)));
endmodule

// File: rtl/prd_flag_bank.sv
module prd_flag_bank (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [prd_pkg::NSRC-1:0]     evt,
  input  logic [prd_pkg::NSRC-1:0]     en,
  input  logic                         rd,
  output logic [prd_pkg::FLAG_W-1:0]   flags,
  output logic                         irq
);
  import prd_pkg::*;

  logic [NSRC-1:0] f_q, f_d;
  logic            sum;

  // a read clears the held flags; events in the read cycle survive
  always_comb f_d = (rd ? '0 : f_q) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= f_d;
  end

  assign sum   = summary_of(f_q, en);
  assign flags = pack_flags(sum, f_q);
  assign irq   = sum;

  assert_per_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt[SRC_PER] |=> flags[BIT_PER]);
  assert_alm_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt[SRC_ALM] |=> flags[BIT_ALM]);
  assert_upd_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt[SRC_UPD] |=> flags[BIT_UPD]);
  assert_rd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (evt == '0)) |=> (flags[BIT_PER:BIT_UPD] == '0));
  assert_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flags[BIT_UPD-1:0] == '0);
endmodule

// File: rtl/prd_rate_irq_unit.sv
module prd_rate_irq_unit #(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [2:0]        div_ctl,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              per_ie,
  input  logic              alm_ie,
  input  logic              upd_ie,
  input  logic              sqw_en,
  input  logic              alarm_evt,
  input  logic              update_evt,
  input  logic              flag_rd,
  output logic [7:0]        flags,
  output logic              irq,
  output logic              sqw
);
  import prd_pkg::*;

  logic            rate_evt;
  logic            div_held;
  logic            rate_on;
  logic [NSRC-1:0] src_evt;
  logic [NSRC-1:0] src_en;

  assign rate_on = (rate_code != '0);
  assign src_evt = {rate_evt, alarm_evt, update_evt};
  assign src_en  = {per_ie, alm_ie, upd_ie};

  prd_divider #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_ctl(div_ctl),
    .rate_code(rate_code), .rate_evt(rate_evt), .held(div_held)
  );

  prd_sqwave u_sqw (
    .clk(clk), .rst_n(rst_n), .rate_evt(rate_evt), .sqw_en(sqw_en),
    .rate_on(rate_on), .sqw(sqw)
  );

  prd_flag_bank u_flg (
    .clk(clk), .rst_n(rst_n), .evt(src_evt), .en(src_en), .rd(flag_rd),
    .flags(flags), .irq(irq)
  );

  assert_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags[BIT_PER:BIT_UPD] & src_en) == '0) |-> !irq);
  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags[BIT_PER:BIT_UPD] != '0));
  assert_held_noflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_held && !alarm_evt && !update_evt && flag_rd) |=> (flags[BIT_PER:BIT_UPD] == '0));
endmodule

// File: tb/prd_rate_irq_unit_tb.sv
module prd_rate_irq_unit_tb;
  localparam int CNT_W = 15;
  localparam int MOD   = 1 << CNT_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [2:0] div_ctl = 3'd2;
  logic [3:0] rate_code = 4'd0;
  logic       per_ie = 1'b0, alm_ie = 1'b0, upd_ie = 1'b0, sqw_en = 1'b0;
  logic       alarm_evt = 1'b0, update_evt = 1'b0, flag_rd = 1'b0;
  logic [7:0] flags;
  logic       irq, sqw;

  int    n_chk = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  prd_rate_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_ctl(div_ctl),
    .rate_code(rate_code), .per_ie(per_ie), .alm_ie(alm_ie), .upd_ie(upd_ie),
    .sqw_en(sqw_en), .alarm_evt(alarm_evt), .update_evt(update_evt),
    .flag_rd(flag_rd), .flags(flags), .irq(irq), .sqw(sqw)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: tick count, modulo test on the period
  int m_cnt = 0;
  bit m_p = 0, m_a = 0, m_u = 0, m_sq = 0;
  bit m_held, m_ev, m_sum;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_p = 0; m_a = 0; m_u = 0; m_sq = 0;
    end else begin
      m_held = (div_ctl >= 3'd6);
      m_ev = tick_en && !m_held && (rate_code != 0) &&
             (((m_cnt + 1) % (1 << rate_code)) == 0);
      if (m_held)       m_cnt = 0;
      else if (tick_en) m_cnt = (m_cnt + 1) % MOD;
      if (flag_rd) begin m_p = 0; m_a = 0; m_u = 0; end
      if (m_ev)       m_p = 1;
      if (alarm_evt)  m_a = 1;
      if (update_evt) m_u = 1;
      if (!sqw_en || rate_code == 0) m_sq = 0;
      else if (m_ev)                 m_sq = !m_sq;
    end
    #2;
    if (rst_n && !done) begin
      m_sum = (m_p && per_ie) || (m_a && alm_ie) || (m_u && upd_ie);
      chk({"R5/", phase}, int'(flags[6]), int'(m_p));
      chk({"R6/", phase}, int'(flags[5:4]), int'({m_a, m_u}));
      chk("R6 low bits", int'(flags[3:0]), 0);
      chk("R8 summary", int'(flags[7]), int'(m_sum));
      chk("R9 irq", int'(irq), int'(flags[7]));
      chk("R10 sqw", int'(sqw), int'(m_sq));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = (gap <= 1) ? 1'b1 : ((i % gap) == 0);
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse_read;
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  initial begin
    cyc(3);
    #2;
    chk("R1 flags", int'(flags), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 sqw", int'(sqw), 0);
    @(negedge clk); rst_n = 1'b1;

    phase = "R2"; rate_code = 4'd1; per_ie = 1'b1;
    run(40, 1); pulse_read;
    rate_code = 4'd3; run(200, 3); pulse_read;
    per_ie = 1'b0; rate_code = 4'd5; run(300, 2);
    pulse_read;

    phase = "R7"; alm_ie = 1'b1;
    @(negedge clk); alarm_evt = 1'b1;
    @(negedge clk); alarm_evt = 1'b0; upd_ie = 1'b0;
    @(negedge clk); update_evt = 1'b1; flag_rd = 1'b1;
    @(negedge clk); update_evt = 1'b0; flag_rd = 1'b0;
    cyc(2); upd_ie = 1'b1; cyc(2);
    @(negedge clk); alarm_evt = 1'b1; update_evt = 1'b1; flag_rd = 1'b1;
    @(negedge clk); alarm_evt = 1'b0; update_evt = 1'b0; flag_rd = 1'b0;
    cyc(2); alm_ie = 1'b0; upd_ie = 1'b0; cyc(2); pulse_read;

    phase = "R3"; rate_code = 4'd0; sqw_en = 1'b1; per_ie = 1'b1;
    run(200, 1);

    phase = "R4"; rate_code = 4'd2; div_ctl = 3'd6; run(50, 1);
    pulse_read; div_ctl = 3'd7; run(30, 1);
    div_ctl = 3'd2; run(100, 1); pulse_read;

    phase = "R10"; sqw_en = 1'b1; rate_code = 4'd2; run(100, 1);
    sqw_en = 1'b0; run(20, 1); sqw_en = 1'b1; rate_code = 4'd4; run(100, 2);

    phase = "R2"; rate_code = 4'd15; pulse_read; run(33000, 1); pulse_read;
    run(33000, 1);

    phase = "MIX";
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      tick_en    = ($urandom_range(0, 3) != 0);
      alarm_evt  = ($urandom_range(0, 30) == 0);
      update_evt = ($urandom_range(0, 30) == 0);
      flag_rd    = ($urandom_range(0, 12) == 0);
      if ($urandom_range(0, 200) == 0) rate_code = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 100) == 0) {per_ie, alm_ie, upd_ie, sqw_en} = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 400) == 0) div_ctl = 3'($urandom_range(0, 7));
    end
    @(negedge clk);
    tick_en = 1'b0; alarm_evt = 1'b0; update_evt = 1'b0; flag_rd = 1'b0;
    cyc(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule